// File: doc/BRIEF.md
# Start-Bit Width Baud Detector

This block sits beside a serial receiver and works out the line rate from the first character a remote sender transmits. Once armed, it waits for the receive line to fall. It then counts reference-clock cycles for as long as the line stays low. The first rise of the line ends the measurement.

The cycle count is latched into a readable count register, and a lock interrupt can be raised. If automatic programming is on, a divisor for a 16x-oversampling baud generator is computed from the count. The block presents that divisor as a low byte and a high byte, together with a one-cycle write strobe for the divisor latch.

The measurement relies on the first data bit being a 1. A leading 0 data bit merges with the start bit and produces a doubled count and a wrong divisor. This behaviour is kept on purpose. After each lock the detector stays idle until software enables it again.

Top module: `autobaud_detect`

## Requirements
- R1: After reset the count register, both divisor bytes, the write strobe and the interrupt are 0, and the detector is disarmed.
- R2: A low-to-high change of `measure_en` arms the detector. A measurement starts only on a high-to-low change of the synchronized line seen while armed. A line that is already low when arming starts nothing.
- R3: The count register receives the number of clock cycles during which the synchronized line stayed low. The measurement ends at the first rise, so a 0 first data bit adds its own length to the count.
- R4: The count saturates at 2^CNT_W-1 and does not wrap.
- R5: With `autoprog_en` high, a lock drives `div_hi`:`div_lo` to floor((count+8)/16), rounded to nearest. `div_lo` carries bits 7:0 and `div_hi` carries bits 15:8. `div_we` pulses for exactly one cycle, in the same cycle the count register updates. With `autoprog_en` low, the divisor outputs do not change and no strobe is given.
- R6: A count below 8, whose rounded divisor would be 0, never writes the divisor or pulses `div_we`.
- R7: `lock_irq` goes high on a lock only if `irq_en` is high. It stays high until an `irq_ack` pulse. A new lock in the same cycle as an acknowledge wins.
- R8: After a lock the detector disarms. Further line pulses change nothing until `measure_en` makes a new low-to-high change.
- R9: Dropping `measure_en` during a measurement aborts it and leaves the count register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_raw | input | 1 | Asynchronous receive line, idle high |
| measure_en | input | 1 | Detection enable; a rising change arms |
| irq_en | input | 1 | Allows the lock interrupt |
| autoprog_en | input | 1 | Allows automatic divisor writes |
| irq_ack | input | 1 | One-cycle interrupt clear |
| baud_count | output | CNT_W | Last measured low-pulse length |
| div_lo | output | 8 | Divisor bits 7:0 |
| div_hi | output | 8 | Divisor bits 15:8 |
| div_we | output | 1 | One-cycle divisor write strobe |
| lock_irq | output | 1 | Lock interrupt, held until acknowledged |

## Verification
A sweep applies every start-bit length from 1 to 200 cycles. It compares the count with the pulse length and the divisor with rounded division by 16. This separates off-by-one counting and truncating versus rounding, and it shows the cut-off below 8. A start bit followed by a 0 data bit must give the summed length. A pulse longer than the counter range shows saturation against wrapping. Pulses sent while disarmed, while the line is already low, or with enable dropped mid-pulse must leave every output alone. Runs with the interrupt or auto-programming disabled show that those paths are gated independently.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_MEAS  = 2'd2
  } abd_state_e;
endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign dout = chain[STAGES-1];
  assign rise = dout & ~prev;
  assign fall = ~dout & prev;
endmodule

// File: rtl/abd_satcnt.sv
module abd_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_one,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load_one)    cnt <= W'(1);
    else if (inc && cnt != MAXV) cnt <= cnt + W'(1);
  end

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !load_one && cnt == MAXV) |=> (cnt == MAXV));
endmodule

// File: rtl/abd_divcalc.sv
module abd_divcalc #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  output logic [DIV_W-1:0] div,
  output logic             div_ok
);
  localparam int SUM_W = CNT_W + 1;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum    = SUM_W'(cnt) + SUM_W'(8);
    div    = DIV_W'(sum >> 4);
    div_ok = (cnt >= CNT_W'(8));
  end
endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect #(
  parameter int CNT_W     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_raw,
  input  logic             measure_en,
  input  logic             irq_en,
  input  logic             autoprog_en,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] baud_count,
  output logic [7:0]       div_lo,
  output logic [7:0]       div_hi,
  output logic             div_we,
  output logic             lock_irq
);
  import abd_pkg::*;
  localparam int DIV_W = 16;

  abd_state_e       state;
  logic             en_q;
  logic             rx_s, rx_rise, rx_fall;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] div_calc;
  logic             div_ok;
  logic             start_meas, lock_now;

  abd_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst(rst), .din(rx_raw),
    .dout(rx_s), .rise(rx_rise), .fall(rx_fall)
  );

  assign start_meas = (state == ST_ARMED) && measure_en && rx_fall;
  assign lock_now   = (state == ST_MEAS) && measure_en && rx_s;

  abd_satcnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load_one(start_meas),
    .inc((state == ST_MEAS) && !rx_s), .cnt(cnt)
  );

  abd_divcalc #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_div (
    .cnt(cnt), .div(div_calc), .div_ok(div_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      en_q       <= 1'b0;
      baud_count <= '0;
      div_lo     <= '0;
      div_hi     <= '0;
      div_we     <= 1'b0;
      lock_irq   <= 1'b0;
    end else begin
      en_q   <= measure_en;
      div_we <= 1'b0;
      if (irq_ack) lock_irq <= 1'b0;
      unique case (state)
        ST_IDLE:  if (measure_en && !en_q) state <= ST_ARMED;
        ST_ARMED: begin
          if (!measure_en)  state <= ST_IDLE;
          else if (rx_fall) state <= ST_MEAS;
        end
        ST_MEAS: begin
          if (!measure_en) state <= ST_IDLE;
          else if (rx_s) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (lock_now) begin
        baud_count <= cnt;
        if (irq_en) lock_irq <= 1'b1;
        if (autoprog_en && div_ok) begin
          div_lo <= div_calc[7:0];
          div_hi <= div_calc[15:8];
          div_we <= 1'b1;
        end
      end
    end
  end

  // R5
  we_single_chk: assert property (@(posedge clk) disable iff (rst)
    div_we |=> !div_we);
  // R5
  we_gated_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(div_we) |-> $past(autoprog_en));
  // R6
  we_min_chk: assert property (@(posedge clk) disable iff (rst)
    div_we |-> (baud_count >= CNT_W'(8)));
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_irq) |-> $past(irq_en));
  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_irq && !irq_ack) |=> lock_irq);
  // R9
  count_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(lock_now) |-> $stable(baud_count));
endmodule

// File: tb/autobaud_detect_test.sv
module autobaud_detect_test;
  localparam int CNT_W = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_raw = 1'b1, measure_en = 1'b0, irq_en = 1'b1, autoprog_en = 1'b1, irq_ack = 1'b0;
  logic [CNT_W-1:0] baud_count;
  logic [7:0] div_lo, div_hi;
  logic div_we, lock_irq;
  int n_chk = 0, n_fail = 0, we_pulses = 0;

  always #5 clk = ~clk;

  autobaud_detect #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .rx_raw(rx_raw), .measure_en(measure_en),
    .irq_en(irq_en), .autoprog_en(autoprog_en), .irq_ack(irq_ack),
    .baud_count(baud_count), .div_lo(div_lo), .div_hi(div_hi),
    .div_we(div_we), .lock_irq(lock_irq)
  );

  always @(negedge clk) if (!rst && div_we) we_pulses++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic arm();
    @(negedge clk) measure_en = 1'b0;
    @(negedge clk) measure_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic low_pulse(input int n);
    @(negedge clk) rx_raw = 1'b0;
    repeat (n) @(negedge clk);
    rx_raw = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int we0, exp_div, prev_div;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(baud_count == 0 && div_lo == 0 && div_hi == 0, "R1 regs", baud_count, 0);
    check(!div_we && !lock_irq, "R1 flags", {div_we, lock_irq}, 0);
    low_pulse(20);  // R1 disarmed out of reset
    check(baud_count == 0, "R1 disarmed", baud_count, 0);

    // R3 R5 R6 sweep of start-bit lengths
    prev_div = 0;
    for (int n = 1; n <= 200; n++) begin
      arm();
      we0 = we_pulses;
      low_pulse(n);
      exp_div = (n + 8) / 16;
      check(baud_count == n, "R3 count", baud_count, n);
      if (n >= 8) begin
        check({div_hi, div_lo} == exp_div, "R5 divisor", {div_hi, div_lo}, exp_div);
        check(we_pulses - we0 == 1, "R5 strobe", we_pulses - we0, 1);
        prev_div = exp_div;
      end else begin
        check(we_pulses == we0, "R6 no strobe", we_pulses - we0, 0);
        check({div_hi, div_lo} == prev_div, "R6 divisor held", {div_hi, div_lo}, prev_div);
      end
      check(lock_irq == 1'b1, "R7 irq set", lock_irq, 1);
      ack();
      check(lock_irq == 1'b0, "R7 irq ack", lock_irq, 0);
    end

    // R8 disarmed after lock
    we0 = we_pulses;
    low_pulse(40);
    check(baud_count == 200, "R8 ignored count", baud_count, 200);
    check(we_pulses == we0 && !lock_irq, "R8 ignored strobe", we_pulses - we0, 0);

    // R3 zero first data bit doubles the low time
    arm();
    low_pulse(64 + 64);
    check(baud_count == 128, "R3 zero data bit", baud_count, 128);
    check({div_hi, div_lo} == 8, "R3 wrong divisor", {div_hi, div_lo}, 8);
    ack();

    // R7 irq disabled, R5 autoprog disabled
    irq_en = 1'b0; autoprog_en = 1'b0;
    arm();
    we0 = we_pulses;
    low_pulse(48);
    check(baud_count == 48, "R7 count still taken", baud_count, 48);
    check(!lock_irq, "R7 irq gated", lock_irq, 0);
    check(we_pulses == we0 && {div_hi, div_lo} == 8, "R5 no autoprog", {div_hi, div_lo}, 8);
    irq_en = 1'b1; autoprog_en = 1'b1;

    // R2 line already low when armed
    @(negedge clk) rx_raw = 1'b0;
    repeat (4) @(negedge clk);
    arm();
    repeat (10) @(negedge clk);
    rx_raw = 1'b1;
    repeat (6) @(negedge clk);
    check(baud_count == 48 && !lock_irq, "R2 no start on low line", baud_count, 48);
    low_pulse(33);  // still armed: falling edge now counts
    check(baud_count == 33, "R2 fall starts", baud_count, 33);
    ack();

    // R9 abort by dropping enable
    arm();
    @(negedge clk) rx_raw = 1'b0;
    repeat (10) @(negedge clk);
    measure_en = 1'b0;
    repeat (10) @(negedge clk);
    rx_raw = 1'b1;
    repeat (6) @(negedge clk);
    check(baud_count == 33 && !lock_irq, "R9 abort", baud_count, 33);

    // R4 saturation
    arm();
    low_pulse(70000);
    check(baud_count == 65535, "R4 saturate", baud_count, 65535);
    check({div_hi, div_lo} == 4096, "R4 divisor", {div_hi, div_lo}, 4096);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule